// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received Ethernet frames into memory under the control of a ring of descriptors that software prepares. Each descriptor is four 32-bit words at consecutive addresses: an ownership/status word, a control word carrying the buffer size and the link flags, a buffer address, and a second address that can hold the link to the next descriptor. The engine fetches the current descriptor ahead of the next frame. It writes the frame bytes into the buffer and then returns the descriptor to software. To do that it clears the ownership bit and records the length and an error flag in the same status word.

Software loads the ring base through a load strobe. It hands descriptors to the engine by setting their ownership bit. When the engine meets a descriptor it does not own, it waits, and a poll strobe makes it check the descriptor again. A frame that finds no descriptor ready is discarded and counted. Each completed frame raises a two-bit interrupt status that the host clears by writing ones.

Top module: `rxdesc_dma`

## Requirements
- R1: After reset, int_stat is 0, irq is 0 and missed_cnt is 0. The engine makes no memory access until base_ld or poll.
- R2: A descriptor fetch first reads the status word at the current address A. read data arrives one cycle after the request. If status bit 31 (owned) is 1, the engine goes on to read A+4 (control), A+8 (buffer address) and A+12 (link address).
- R3: Byte n of a frame is written to address B+n, where B is the buffer address. The write uses the word-aligned address, a single byte enable for lane (B+n)[1:0], and the byte replicated on all four lanes. Bytes are written in arrival order.
- R4: On frame end, the engine writes the word at A with all byte enables set. Bit 31 is 0, bits 26:16 hold the byte count of the frame (including CRC), bit 15 is the error flag, and all other bits are 0.
- R5: Bytes at positions at or beyond the control-word size (bits 10:0) are not written. Such a frame sets status bit 15, and its length field still holds the full byte count.
- R6: rx_err asserted with any byte of an accepted frame sets status bit 15.
- R7: The next descriptor address is the ring base if control bit 25 (end of ring) is set. Otherwise it is the link address if control bit 24 (chained) is set, and A+16 if neither bit is set. End of ring takes priority over chained. The fetch of the next descriptor begins on the cycle after the status write.
- R8: A fetch that reads owned=0 stops the engine after that single read. The engine then makes no memory access until poll, which reads the status word at A again. Frames that start while the engine waits are dropped and each one adds 1 to missed_cnt.
- R9: A frame whose start byte arrives while a descriptor is being fetched or written back is dropped: none of its bytes is written, and missed_cnt rises by 1.
- R10: Each status write sets int_stat to 2'b11 (interrupt status bits 7:6) and raises irq, which is the OR of int_stat. Writing a 1 to a bit of stat_clr clears that bit. A set in the same cycle wins over a clear.
- R11: base_ld loads the ring base and the current address from base_data and starts a fetch there on the next cycle, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_ld | input | 1 | Load strobe for the ring base |
| base_data | input | 32 | Ring base address |
| poll | input | 1 | Poll strobe: recheck ownership while waiting |
| rx_valid | input | 1 | Frame byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Receive error flag for this byte |
| rx_data | input | 8 | Frame byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| stat_clr | input | 2 | Write-one-to-clear for int_stat |
| int_stat | output | 2 | Frame-received interrupt status (bits 7:6) |
| irq | output | 1 | Interrupt request |
| missed_cnt | output | 16 | Dropped-frame count, saturating |

## Verification
A wrong current-descriptor pointer or link decision shows up within one cycle of the status write: the next read request goes to an address other than the one predicted. A wrong byte counter shows as a wrong lane or address on the next byte write, or a wrong length in the status word at frame end. A state machine stuck in fetch or waiting shows as missing bytes and an extra count on missed_cnt for the next frame. The scoreboard compares every memory request against the predicted sequence as it appears, so each of these faults is seen in the cycle it occurs.

// File: rtl/rxdesc_dma.sv
module rxdesc_dma #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_ld,
  input  logic [31:0]       base_data,
  input  logic              poll,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [7:0]        rx_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic [1:0]        stat_clr,
  output logic [1:0]        int_stat,
  output logic              irq,
  output logic [MISS_W-1:0] missed_cnt
);
  localparam int LEN_W = 11;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [31:0] DESC_STEP = 32'd16;

  typedef enum logic [3:0] {S_WAIT, S_F0, S_F1, S_F2, S_F3, S_F4, S_RDY, S_RX, S_WB} st_t;
  st_t state;

  logic [31:0] base_r, cur, buf1_r, buf2_r;
  logic [LEN_W-1:0] size_r, rlen;
  logic eor_r, chain_r, err_r, trunc_r;

  wire accept  = rx_valid && ((state == S_RDY && rx_sof) || state == S_RX);
  wire fits    = rlen < size_r;
  wire wr_byte = accept && fits;
  wire [31:0] baddr = buf1_r + {{(32-LEN_W){1'b0}}, rlen};
  wire [31:0] nxt = eor_r ? base_r : (chain_r ? buf2_r : cur + DESC_STEP);
  wire [31:0] status_w = {1'b0, 4'b0, rlen, err_r | trunc_r, 15'b0};
  wire dropped = rx_valid && rx_sof && !(state == S_RDY || state == S_RX);
  wire [LEN_W-1:0] rlen_inc = (rlen == LEN_MAX) ? rlen : rlen + 1'b1;

  assign irq = |int_stat;

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = cur; mem_be = 4'h0; mem_wdata = 32'h0;
    case (state)
      S_F0: mem_req = 1'b1;
      S_F1: begin mem_req = mem_rdata[31]; mem_addr = cur + 32'd4; end
      S_F2: begin mem_req = 1'b1; mem_addr = cur + 32'd8; end
      S_F3: begin mem_req = 1'b1; mem_addr = cur + 32'd12; end
      S_RDY, S_RX: if (wr_byte) begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {baddr[31:2], 2'b00};
        mem_be = 4'b0001 << baddr[1:0];
        mem_wdata = {4{rx_data}};
      end
      S_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_be = 4'hF; mem_wdata = status_w; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_WAIT; base_r <= '0; cur <= '0; buf1_r <= '0; buf2_r <= '0;
      size_r <= '0; rlen <= '0; eor_r <= 1'b0; chain_r <= 1'b0;
      err_r <= 1'b0; trunc_r <= 1'b0; int_stat <= 2'b00; missed_cnt <= '0;
    end else begin
      int_stat <= (int_stat & ~stat_clr) | ((state == S_WB) ? 2'b11 : 2'b00);
      if (dropped && missed_cnt != '1) missed_cnt <= missed_cnt + 1'b1;
      case (state)
        S_WAIT: if (poll) state <= S_F0;
        S_F0:   state <= S_F1;
        S_F1:   state <= mem_rdata[31] ? S_F2 : S_WAIT;
        S_F2: begin
          size_r <= mem_rdata[LEN_W-1:0]; chain_r <= mem_rdata[24]; eor_r <= mem_rdata[25];
          state <= S_F3;
        end
        S_F3: begin buf1_r <= mem_rdata; state <= S_F4; end
        S_F4: begin buf2_r <= mem_rdata; state <= S_RDY; end
        S_RDY: if (accept) begin
          rlen <= rlen_inc; err_r <= rx_err; trunc_r <= !fits;
          state <= rx_eof ? S_WB : S_RX;
        end
        S_RX: if (accept) begin
          rlen <= rlen_inc; err_r <= err_r | rx_err; trunc_r <= trunc_r | !fits;
          if (rx_eof) state <= S_WB;
        end
        S_WB: begin cur <= nxt; rlen <= '0; state <= S_F0; end
        default: state <= S_WAIT;
      endcase
      if (base_ld) begin
        base_r <= base_data; cur <= base_data; rlen <= '0; state <= S_F0;
      end
    end
  end

  wire status_wr = mem_req && mem_we && mem_be == 4'hF;
  wire byte_wr   = mem_req && mem_we && mem_be != 4'hF;

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |-> $countones(mem_be) == 1);
  assert_fetch_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && !base_ld) |=> (mem_req && !mem_we && mem_addr == $past(nxt)));
  assert_irq_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> int_stat == 2'b11 && irq);
  assert_quiet_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAIT |-> !mem_req);
  assert_missed_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped && missed_cnt != '1) |=> missed_cnt == $past(missed_cnt) + 1'b1);
  assert_trunc_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RX && rx_valid && !fits) |-> !mem_req);
endmodule

// File: tb/rxdesc_dma_tb.sv
`timescale 1ns/1ps
module rxdesc_dma_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic base_ld = 0, poll = 0, rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic [31:0] base_data = 0;
  logic [7:0] rx_data = 0;
  logic [1:0] stat_clr = 0;
  logic mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [1:0] int_stat;
  logic [15:0] missed_cnt;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxdesc_dma dut_i (.clk, .rst_n, .base_ld, .base_data, .poll, .rx_valid, .rx_sof,
    .rx_eof, .rx_err, .rx_data, .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata,
    .mem_rdata, .stat_clr, .int_stat, .irq, .missed_cnt);

  logic [31:0] mem [0:1023];
  always @(posedge clk) if (mem_req) begin
    if (mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end else mem_rdata <= mem[mem_addr[11:2]];
  end

  typedef struct packed { logic we; logic [31:0] addr; logic [3:0] be; logic [31:0] data; } item_t;
  item_t q[$];
  string qtag[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic push(logic we, logic [31:0] a, logic [3:0] be, logic [31:0] d, string tag);
    q.push_back({we, a, be, d}); qtag.push_back(tag);
  endtask

  task automatic exp_fetch(logic [31:0] a, bit owned, string tag);
    push(0, a, 0, 0, tag);
    if (owned) for (int k = 1; k < 4; k++) push(0, a + 4*k, 0, 0, tag);
  endtask

  function automatic logic [31:0] st_word(int len, bit err);
    return {1'b0, 4'b0, len[10:0], err, 15'b0};
  endfunction

  always @(negedge clk) if (rst_n && mem_req) begin
    if (q.size() == 0) chk(0, "R1 unexpected access", mem_addr, 32'hx);
    else begin
      item_t e; string t;
      e = q.pop_front(); t = qtag.pop_front();
      chk(mem_we == e.we && mem_addr == e.addr, {t, " addr/dir"}, {mem_we, mem_addr[30:0]}, {e.we, e.addr[30:0]});
      if (e.we) begin
        chk(mem_be == e.be, {t, " be"}, {28'h0, mem_be}, {28'h0, e.be});
        for (int b = 0; b < 4; b++)
          if (e.be[b]) chk(mem_wdata[8*b +: 8] == e.data[8*b +: 8], {t, " data"}, mem_wdata, e.data);
      end
    end
  end

  task automatic tick(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic idle_rx; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; endtask

  task automatic send_frame(int n, logic [7:0] seed, int err_at, bit expect_it,
                            logic [31:0] buf1, int size, logic [31:0] da, string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] ba; logic [7:0] d;
      ba = buf1 + i; d = seed + i[7:0];
      if (expect_it && i < size) push(1, {ba[31:2], 2'b00}, 4'b0001 << ba[1:0], {4{d}}, {tag, " R3 byte"});
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_err = (i == err_at); rx_data = d;
      if (i == n - 1 && expect_it) push(1, da, 4'hF, st_word(n, err_at >= 0 || n > size), {tag, " R4 status"});
      if (i != n - 1) tick(1);
    end
  endtask

  task automatic end_frame; tick(1); idle_rx(); endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    mem[32'h100>>2] = 32'h8000_0000; mem[(32'h104)>>2] = 16;       mem[32'h108>>2] = 32'h400;
    mem[32'h110>>2] = 32'h8000_0000; mem[32'h114>>2] = (1<<24)|20; mem[32'h118>>2] = 32'h503; mem[32'h11C>>2] = 32'h200;
    mem[32'h200>>2] = 32'h8000_0000; mem[32'h204>>2] = (3<<24)|16; mem[32'h208>>2] = 32'h600; mem[32'h20C>>2] = 32'h300;
    mem[32'h180>>2] = 32'h8000_0000; mem[32'h184>>2] = 4;          mem[32'h188>>2] = 32'h700;
    tick(3); rst_n = 1; tick(4);
    chk(int_stat == 0, "R1 int_stat", {30'h0, int_stat}, 0);
    chk(irq == 0, "R1 irq", {31'h0, irq}, 0);
    chk(missed_cnt == 0, "R1 missed", {16'h0, missed_cnt}, 0);

    exp_fetch(32'h100, 1, "R11 R2 first fetch");
    base_data = 32'h100; base_ld = 1; tick(1); base_ld = 0; tick(10);

    send_frame(6, 8'h10, -1, 1, 32'h400, 16, 32'h100, "frameA");
    exp_fetch(32'h110, 1, "R7 sequential");
    end_frame(); tick(10);

    send_frame(9, 8'h40, -1, 1, 32'h503, 20, 32'h110, "frameB");
    exp_fetch(32'h200, 1, "R7 chained");
    end_frame(); tick(10);

    send_frame(5, 8'h80, -1, 1, 32'h600, 16, 32'h200, "frameC");
    exp_fetch(32'h100, 0, "R7 end-of-ring priority");
    end_frame(); tick(10);

    chk(int_stat == 2'b11 && irq, "R10 set", {29'h0, irq, int_stat}, 32'h7);
    stat_clr = 2'b01; tick(1); stat_clr = 0;
    chk(int_stat == 2'b10 && irq, "R10 clear bit6", {29'h0, irq, int_stat}, 32'h6);
    stat_clr = 2'b10; tick(1); stat_clr = 0;
    chk(int_stat == 2'b00 && !irq, "R10 clear bit7", {29'h0, irq, int_stat}, 0);

    send_frame(3, 8'hC0, -1, 0, 0, 0, 0, "drop");
    end_frame(); tick(2);
    chk(missed_cnt == 1, "R8 missed while waiting", {16'h0, missed_cnt}, 1);

    exp_fetch(32'h100, 0, "R8 poll recheck");
    poll = 1; tick(1); poll = 0; tick(8);
    mem[32'h100>>2] = 32'h8000_0000;
    exp_fetch(32'h100, 1, "R8 poll owned");
    poll = 1; tick(1); poll = 0; tick(10);

    send_frame(4, 8'h20, 1, 1, 32'h400, 16, 32'h100, "frameD R6");
    exp_fetch(32'h110, 0, "R7 next unowned");
    tick(1);
    send_frame(2, 8'hE0, -1, 0, 0, 0, 0, "drop R9");
    end_frame(); tick(8);
    chk(missed_cnt == 2, "R9 missed during writeback", {16'h0, missed_cnt}, 2);

    exp_fetch(32'h180, 1, "R11 reload base");
    base_data = 32'h180; base_ld = 1; tick(1); base_ld = 0; tick(10);
    send_frame(7, 8'h30, -1, 1, 32'h700, 4, 32'h180, "frameE R5");
    exp_fetch(32'h190, 0, "R7 after truncation");
    end_frame(); tick(10);
    chk(int_stat == 2'b11, "R10 set again", {30'h0, int_stat}, 3);
    chk(missed_cnt == 2, "R5 no extra miss", {16'h0, missed_cnt}, 2);
    chk(mem[32'h704>>2] == 0, "R5 beyond size untouched", mem[32'h704>>2], 0);
    chk(q.size() == 0, "R2 all expected accesses seen", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule